// File: doc/BRIEF.md
# Bit-Level Pipelined Threshold-Logic Adder

This block adds two unsigned operands and an optional carry-in. Its full-adder cells are built from threshold-logic gates. Each cell has two levels. The first level holds three threshold gates that compare the count of ones among the cell's inputs against 1, 2 and 3. The second level holds one gate that weighs those three results +1, −1 and +1 against a threshold of 1. The output of that gate is the sum bit. The ≥2 gate also serves as the carry into the next cell.

Every gate level is followed by a register. The carry therefore moves one bit position per clock. Operand bit i is delayed by i registers so that it meets its incoming carry. Sum bit i is delayed by WIDTH−1−i registers so that all bits of one addition leave together. With one new operand pair on every clock, results come out at the same rate, WIDTH+1 clocks later. A valid flag travels with the data.

While nothing valid is in flight, the pipeline registers are frozen.

Top module: `thr_pipe_adder`

## Requirements
- R1: For each accepted input (inValid=1), the output {carryOut, sumOut} equals opA + opB + carryIn, computed as a WIDTH+1 bit unsigned result.
- R2: outValid is 1 in exactly the cycle WIDTH+1 clocks after the clock edge that took an input with inValid=1. outValid is 0 in every other cycle.
- R3: Inputs may be presented on every consecutive clock. Each one yields its own result, and the results arrive on consecutive clocks in input order.
- R4: A synchronous active-high rst clears outValid, sumOut and carryOut to 0 on the next clock.
- R5: Inside each cell, the sum bit is 1 exactly when the number of ones among {a_i, b_i, c_in} is 1 or 3. The carry is 1 when that number is 2 or more.
- R6: With HAS_CIN=1, carryIn adds one at bit 0. Example: all-ones + 0 + carryIn=1 gives carryOut=1 and sumOut=0.
- R7: When no valid input is in flight and inValid is 0, sumOut and carryOut hold their values even if opA, opB or carryIn change.
- R8: For WIDTH=8: FF+FF gives carry 1, sum FE. 00+FF gives carry 0, sum FF. 00+00 gives carry 0, sum 00.
- R9: An rst asserted while additions are in flight discards them: outValid stays 0 until a new input has travelled the full WIDTH+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair on this clock is to be added |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 (ignored when HAS_CIN=0) |
| outValid | output | 1 | sumOut/carryOut hold a result this cycle |
| sumOut | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The clearest collision is between the pipeline freeze and the last result of a burst. In the cycle where the final valid data reaches the deskew registers, the freeze strobe may drop. If it drops one cycle early, the top bits of that result are lost.

The bench streams 65,536 operand pairs back to back and then stops. Each result is judged against arithmetic at its exact arrival cycle. The held outputs are then compared while the operands wander.

A reset issued with three additions in flight provokes the second collision, reset against drain. The bench judges it by the absence of outValid.

// File: rtl/thr_pipe_adder_pkg.sv
package thr_pipe_adder_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // synchronous clear of every register
    logic advance;  // shift all pipeline and delay registers
  } thrStrobe_t;

  // Generic threshold gate: fires when the weighted input sum reaches theta
  function automatic logic thrFire(input int weighted, input int theta);
    return (weighted >= theta);
  endfunction

endpackage

// File: rtl/thr_pipe_adder_cell.sv
module thr_pipe_adder_cell
  import thr_pipe_adder_pkg::*;
(
  input  logic       clk,
  input  thrStrobe_t strb,
  input  logic       bitA,
  input  logic       bitB,
  input  logic       cin,
  output logic       cout,
  output logic       sumBit
);

  logic [1:0] onesCnt;
  logic       geOne, geTwo, geThree;
  logic       sumNext;

  assign onesCnt = 2'(bitA) + 2'(bitB) + 2'(cin);

  // level 1: three gates classify the input count
  always_ff @(posedge clk) begin
    if (strb.clear) begin
      geOne   <= 1'b0;
      geTwo   <= 1'b0;
      geThree <= 1'b0;
    end else if (strb.advance) begin
      geOne   <= thrFire(int'(onesCnt), 1);
      geTwo   <= thrFire(int'(onesCnt), 2);
      geThree <= thrFire(int'(onesCnt), 3);
    end
  end

  // level 2: weights +1 / -1 / +1 against threshold 1 (count is 1 or 3)
  assign sumNext = thrFire(int'(geOne) - int'(geTwo) + int'(geThree), 1);

  always_ff @(posedge clk) begin
    if (strb.clear)        sumBit <= 1'b0;
    else if (strb.advance) sumBit <= sumNext;
  end

  assign cout = geTwo;

endmodule

// File: rtl/thr_pipe_adder_dp.sv
module thr_pipe_adder_dp
  import thr_pipe_adder_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit HAS_CIN = 1'b1
) (
  input  logic             clk,
  input  thrStrobe_t       strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  logic [WIDTH-1:0] carryChain;
  logic             cinEff;

  if (HAS_CIN) begin : g_cin
    assign cinEff = carryIn;
  end else begin : g_nocin
    assign cinEff = 1'b0;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int DESKEW = WIDTH - 1 - i;
    logic [i:0]      aTap, bTap;
    logic [DESKEW:0] sTap;
    logic            cellCin;

    // input skew: bit i waits i stages for its carry
    assign aTap[0] = opA[i];
    assign bTap[0] = opB[i];
    always_ff @(posedge clk) begin
      for (int k = 1; k <= i; k++) begin
        if (strb.clear) begin
          aTap[k] <= 1'b0;
          bTap[k] <= 1'b0;
        end else if (strb.advance) begin
          aTap[k] <= aTap[k-1];
          bTap[k] <= bTap[k-1];
        end
      end
    end

    if (i == 0) begin : g_lsb
      assign cellCin = cinEff;
    end else begin : g_upper
      assign cellCin = carryChain[i-1];
    end

    thr_pipe_adder_cell cell_i (
      .clk    (clk),
      .strb   (strb),
      .bitA   (aTap[i]),
      .bitB   (bTap[i]),
      .cin    (cellCin),
      .cout   (carryChain[i]),
      .sumBit (sTap[0])
    );

    // output deskew: lower bits wait for the top bit
    always_ff @(posedge clk) begin
      for (int k = 1; k <= DESKEW; k++) begin
        if (strb.clear)        sTap[k] <= 1'b0;
        else if (strb.advance) sTap[k] <= sTap[k-1];
      end
    end

    assign sumOut[i] = sTap[DESKEW];
  end

  // carry out is ready one stage before the top sum bit
  always_ff @(posedge clk) begin
    if (strb.clear)        carryOut <= 1'b0;
    else if (strb.advance) carryOut <= carryChain[WIDTH-1];
  end

endmodule

// File: rtl/thr_pipe_adder_ctrl.sv
module thr_pipe_adder_ctrl
  import thr_pipe_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output thrStrobe_t strb,
  output logic       outValid
);

  localparam int DEPTH = WIDTH + 1;

  logic [DEPTH-1:0] validChain;

  always_ff @(posedge clk) begin
    if (rst) validChain <= '0;
    else     validChain <= {validChain[DEPTH-2:0], inValid};
  end

  // freeze the datapath once nothing valid remains to be moved
  assign strb.clear   = rst;
  assign strb.advance = inValid | (|validChain[DEPTH-2:0]);
  assign outValid     = validChain[DEPTH-1];

endmodule

// File: rtl/thr_pipe_adder.sv
module thr_pipe_adder
  import thr_pipe_adder_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit HAS_CIN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic             outValid,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  thrStrobe_t strb;

  thr_pipe_adder_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  thr_pipe_adder_dp #(.WIDTH(WIDTH), .HAS_CIN(HAS_CIN)) dp_i (
    .clk      (clk),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/thr_pipe_adder_chk.sv
module thr_pipe_adder_chk
  import thr_pipe_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input thrStrobe_t       strb
);

  localparam int DEPTH = WIDTH + 1;

  logic [DEPTH-1:0] shadowValid;
  logic [31:0]      inCnt, outCnt;
  logic             pastRst;

  always_ff @(posedge clk) begin
    pastRst <= rst;
    if (rst) begin
      shadowValid <= '0;
      inCnt       <= '0;
      outCnt      <= '0;
    end else begin
      shadowValid <= {shadowValid[DEPTH-2:0], inValid};
      inCnt       <= inCnt + 32'(inValid);
      outCnt      <= outCnt + 32'(outValid);
    end
  end

  // R2 / R9: outValid follows the accepted inputs at a fixed delay
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    outValid == shadowValid[DEPTH-1]);

  // R3: never more results owed than pipeline stages
  a_r3_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    (outCnt <= inCnt) && ((inCnt - outCnt) <= 32'(DEPTH)));

  // R7: frozen pipeline keeps its outputs
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> $stable(sumOut) && $stable(carryOut));

  // R4: reset clears the outputs on the following clock
  always_ff @(posedge clk) begin
    if (pastRst) begin
      a_r4_reset_clears: assert (!outValid && sumOut == '0 && !carryOut);
    end
  end

endmodule

bind thr_pipe_adder thr_pipe_adder_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/thr_pipe_adder_tb_top.sv
`timescale 1ns/1ps
module thr_pipe_adder_tb_top;

  localparam int WIDTH = 8;
  localparam int DEPTH = WIDTH + 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             inValid;
  logic [WIDTH-1:0] opA, opB;
  logic             carryIn;
  logic             outValid;
  logic [WIDTH-1:0] sumOut;
  logic             carryOut;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit done   = 0;

  logic [WIDTH:0] expQ[$];
  int             expCyc[$];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cycle <= cycle + 1;

  thr_pipe_adder #(.WIDTH(WIDTH), .HAS_CIN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .carryIn(carryIn), .outValid(outValid), .sumOut(sumOut), .carryOut(carryOut)
  );

  task automatic check(input bit ok, input string req, input logic [WIDTH:0] act,
                       input logic [WIDTH:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // result monitor: R1 value, R2 / R3 arrival cycle
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected outValid", {carryOut, sumOut}, '0);
      end else begin
        logic [WIDTH:0] e;
        int             c;
        e = expQ.pop_front();
        c = expCyc.pop_front();
        check({carryOut, sumOut} == e, "R1 sum", {carryOut, sumOut}, e);
        check(cycle - c == DEPTH, "R2/R3 latency", (WIDTH+1)'(cycle - c), (WIDTH+1)'(DEPTH));
      end
    end
  end

  task automatic issue(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input logic ci);
    inValid = 1'b1; opA = a; opB = b; carryIn = ci;
    expQ.push_back((WIDTH+1)'(a) + (WIDTH+1)'(b) + (WIDTH+1)'(ci));
    expCyc.push_back(cycle);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; opA = '0; opB = '0; carryIn = 1'b0;
    repeat (3) @(negedge clk);
    // R4 reset state
    check(!outValid && sumOut == '0 && !carryOut, "R4 reset state",
          {carryOut, sumOut}, '0);
    rst = 1'b0;
    @(negedge clk);

    // R8 corners and R6 carry-in
    issue(8'hFF, 8'hFF, 1'b0);   // R8: 1_FE
    issue(8'h00, 8'hFF, 1'b0);   // R8: 0_FF
    issue(8'h00, 8'h00, 1'b0);   // R8: 0_00
    issue(8'hFF, 8'h00, 1'b1);   // R6: 1_00
    // R5: every count of ones at one cell (bit 0 and bit 3)
    for (int v = 0; v < 8; v++) issue(8'(v[0]), 8'(v[1]), v[2]);
    for (int v = 0; v < 4; v++) issue(8'(v[0]) << 3, 8'(v[1]) << 3, 1'b0);
    idle(DEPTH + 2);
    check(expQ.size() == 0, "R5/R8 all results drained", (WIDTH+1)'(expQ.size()), '0);

    // R1 / R3: back-to-back sweep over every operand pair
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        issue(8'(a), 8'(b), a[0] ^ b[1]);
    idle(DEPTH + 2);
    check(expQ.size() == 0, "R3 every result delivered", (WIDTH+1)'(expQ.size()), '0);

    // R7: hold while idle with wandering operands
    begin
      logic [WIDTH:0] held;
      held = {carryOut, sumOut};
      for (int k = 0; k < 6; k++) begin
        opA = 8'(k * 37 + 5); opB = 8'(k * 91 + 3); carryIn = k[0];
        @(negedge clk);
        check({carryOut, sumOut} == held && !outValid, "R7 hold when idle",
              {carryOut, sumOut}, held);
      end
    end

    // R9: reset with additions in flight
    issue(8'h12, 8'h34, 1'b0);
    issue(8'h56, 8'h78, 1'b1);
    issue(8'h9A, 8'hBC, 1'b0);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    expQ.delete(); expCyc.delete();
    check(!outValid && sumOut == '0 && !carryOut, "R4 reset mid-flight",
          {carryOut, sumOut}, '0);
    rst = 1'b0;
    for (int k = 0; k < DEPTH + 3; k++) begin
      @(negedge clk);
      check(!outValid, "R9 in-flight work discarded", (WIDTH+1)'(outValid), '0);
    end
    issue(8'h80, 8'h80, 1'b1);   // R9: fresh input still works, expect 1_01
    idle(DEPTH + 2);
    check(expQ.size() == 0, "R9 result after reset", (WIDTH+1)'(expQ.size()), '0);

    done = 1;
  end

  initial begin
    while (!done && cycle < 190000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cycle);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule